// File: doc/BRIEF.md
# Lockable Host Configuration Register Bank

This block holds the host-visible setup registers of a peripheral controller that serves three logical channels: a real-time clock, a keyboard port and a power-management port. Each channel has a 16-bit decode address and an enable bit. Whenever the host strobes a read or write at an address that matches an enabled channel, the block raises that channel's chip select. A movable index/data pair gives access to all of these registers. A byte-wide IRQ enable register drives the output enables of four interrupt pins. The reset value of the IRQ enable register comes from a strap input.

Firmware can freeze any channel's settings, and the location of the index/data pair, through a lock register. Lock bits can only be set. Once a lock bit is set, writes to the fields it covers are dropped without any error, and the frozen values still read back. Only reset clears the lock bits.

Register map (index written at `base`, data at `base+1`): 0x00 channel enables (bit0 clock, bit1 keyboard, bit2 power management), 0x01 locks, 0x02 IRQ enables, 0x03/0x04 base low/high, 0x05/0x06 clock address low/high, 0x07/0x08 keyboard address low/high, 0x09/0x0A power-management address low/high.

Top module: `cfg_lock_regs`

## Requirements
- R1: After reset, the channel enable register and the lock register read 0x00. The base address is 0x002E and the clock, keyboard and power-management addresses are 0x0070, 0x0060 and 0x0062.
- R2: A host write to `base` loads the index. A write to `base+1` updates the register the index selects, and a read of `base+1` returns that register. Unimplemented bits of a register (enable bits 7:3) read as 0.
- R3: Lock bits 0, 1, 2 and 7 are set by writing 1 to them. Writing 0 leaves them set. Bits 6:3 always read 0.
- R4: While lock bit 0, 1 or 2 is set, writes to the matching channel's address bytes (clock, keyboard, power management respectively) and to its enable bit are ignored. The other enable bits stay writable.
- R5: While lock bit 7 is set, writes to both base-address bytes are ignored.
- R6: A channel select is high only while `hst_rd` or `hst_wr` is high, `hst_addr` equals the channel's full 16-bit address, and the channel's enable bit is 1.
- R7: At most one channel select is high at a time. When addresses collide, clock wins over keyboard, and keyboard wins over power management.
- R8: `irq_oe[3:0]` follows IRQ enable bits 3:0 (IRQ1, IRQ12, IRQ11, IRQ8). Bits 7:4 read 0.
- R9: Reset loads the IRQ enable register with 0x0F when `strap_irq_on` is 1, and with 0x00 when it is 0.
- R10: Indices above 0x0A read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_irq_on | input | 1 | Strap selecting the IRQ enable reset value |
| hst_addr | input | 16 | Host address |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Read data from the index/data pair |
| cs_rtc | output | 1 | Clock channel select |
| cs_kbd | output | 1 | Keyboard channel select |
| cs_pm | output | 1 | Power-management channel select |
| irq_oe | output | 4 | Output enables for IRQ1, IRQ12, IRQ11, IRQ8 |

## Verification
The hardest state to reach is a partially frozen enable register. The clock enable must be locked at 1 while the other enable bits stay writable, and this can only be seen through a later write of zeros followed by a read-back. The stimulus first enables all channels, then sets only the clock lock, then clears the enable register and expects 0x01. The base lock is reached after moving the index/data pair, so every later access uses the new window. Select priority is exercised by programming two channels to the same address.

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs #(
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter logic [15:0] BASE_RST    = 16'h002E,
  parameter logic [15:0] RTC_ADR_RST = 16'h0070,
  parameter logic [15:0] KBD_ADR_RST = 16'h0060,
  parameter logic [15:0] PM_ADR_RST  = 16'h0062
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_irq_on,
  input  logic [AW-1:0] hst_addr,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          cs_rtc,
  output logic          cs_kbd,
  output logic          cs_pm,
  output logic [3:0]    irq_oe
);
  localparam logic [DW-1:0] LOCK_MASK = DW'(8'h87);

  logic [DW-1:0] idx_q, lock_q;
  logic [2:0]    fen_q;
  logic [3:0]    irq_q;
  logic [AW-1:0] base_q, rtc_q, kbd_q, pm_q;

  wire at_idx  = hst_addr == base_q;
  wire at_dat  = hst_addr == base_q + AW'(1);
  wire wr_dat  = hst_wr && at_dat;
  wire strobe  = hst_rd || hst_wr;
  wire hit_rtc = strobe && fen_q[0] && hst_addr == rtc_q;
  wire hit_kbd = strobe && fen_q[1] && hst_addr == kbd_q;
  wire hit_pm  = strobe && fen_q[2] && hst_addr == pm_q;

  assign cs_rtc = hit_rtc;
  assign cs_kbd = hit_kbd && !hit_rtc;
  assign cs_pm  = hit_pm && !hit_rtc && !hit_kbd;
  assign irq_oe = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      lock_q <= '0;
      fen_q  <= '0;
      irq_q  <= {4{strap_irq_on}};
      base_q <= BASE_RST;
      rtc_q  <= RTC_ADR_RST;
      kbd_q  <= KBD_ADR_RST;
      pm_q   <= PM_ADR_RST;
    end else begin
      if (hst_wr && at_idx) idx_q <= hst_wdata;
      if (wr_dat) begin
        case (idx_q)
          8'h00: fen_q  <= (fen_q & lock_q[2:0]) | (hst_wdata[2:0] & ~lock_q[2:0]);
          8'h01: lock_q <= lock_q | (hst_wdata & LOCK_MASK);
          8'h02: irq_q  <= hst_wdata[3:0];
          8'h03: if (!lock_q[7]) base_q[7:0]  <= hst_wdata;
          8'h04: if (!lock_q[7]) base_q[15:8] <= hst_wdata;
          8'h05: if (!lock_q[0]) rtc_q[7:0]   <= hst_wdata;
          8'h06: if (!lock_q[0]) rtc_q[15:8]  <= hst_wdata;
          8'h07: if (!lock_q[1]) kbd_q[7:0]   <= hst_wdata;
          8'h08: if (!lock_q[1]) kbd_q[15:8]  <= hst_wdata;
          8'h09: if (!lock_q[2]) pm_q[7:0]    <= hst_wdata;
          8'h0A: if (!lock_q[2]) pm_q[15:8]   <= hst_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [DW-1:0] reg_rd;
  always_comb begin
    case (idx_q)
      8'h00:   reg_rd = {5'b0, fen_q};
      8'h01:   reg_rd = lock_q;
      8'h02:   reg_rd = {4'b0, irq_q};
      8'h03:   reg_rd = base_q[7:0];
      8'h04:   reg_rd = base_q[15:8];
      8'h05:   reg_rd = rtc_q[7:0];
      8'h06:   reg_rd = rtc_q[15:8];
      8'h07:   reg_rd = kbd_q[7:0];
      8'h08:   reg_rd = kbd_q[15:8];
      8'h09:   reg_rd = pm_q[7:0];
      8'h0A:   reg_rd = pm_q[15:8];
      default: reg_rd = '0;
    endcase
  end

  assign hst_rdata = !hst_rd ? '0 : at_idx ? idx_q : at_dat ? reg_rd : '0;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & $past(lock_q)) == $past(lock_q));
  // R4
  rtc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[0] |=> $stable(rtc_q) && $stable(fen_q[0]));
  // R4
  kbd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[1] |=> $stable(kbd_q) && $stable(fen_q[1]));
  // R4
  pm_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[2] |=> $stable(pm_q) && $stable(fen_q[2]));
  // R5
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[7] |=> $stable(base_q));
  // R6
  cs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rtc || cs_kbd || cs_pm) |-> strobe);
  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_rtc, cs_kbd, cs_pm}));
  // R9
  irq_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_oe == {4{strap_irq_on}});
endmodule

// File: tb/cfg_lock_regs_tb.sv
module cfg_lock_regs_tb_top;
  logic clk = 0, rst_n = 0, strap = 1;
  logic [15:0] addr = '0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = '0, rdata;
  logic cs_rtc, cs_kbd, cs_pm;
  logic [3:0] irq_oe;
  logic [15:0] base = 16'h002E;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cfg_lock_regs dut_i (
    .clk(clk), .rst_n(rst_n), .strap_irq_on(strap),
    .hst_addr(addr), .hst_rd(rd), .hst_wr(wr), .hst_wdata(wdata), .hst_rdata(rdata),
    .cs_rtc(cs_rtc), .cs_kbd(cs_kbd), .cs_pm(cs_pm), .irq_oe(irq_oe));

  // {op(0 write,1 read), index, data/expected, requirement}
  localparam logic [31:0] VEC [0:30] = '{
    {8'd1, 8'h00, 8'h00, 8'd1},  // R1
    {8'd1, 8'h01, 8'h00, 8'd1},  // R1
    {8'd1, 8'h02, 8'h0F, 8'd9},  // R9
    {8'd0, 8'h00, 8'hFF, 8'd2},
    {8'd1, 8'h00, 8'h07, 8'd2},  // R2
    {8'd0, 8'h05, 8'h34, 8'd2},
    {8'd1, 8'h05, 8'h34, 8'd2},
    {8'd0, 8'h06, 8'h12, 8'd2},
    {8'd1, 8'h06, 8'h12, 8'd2},
    {8'd0, 8'h01, 8'h01, 8'd3},
    {8'd1, 8'h01, 8'h01, 8'd3},  // R3
    {8'd0, 8'h05, 8'h99, 8'd4},
    {8'd1, 8'h05, 8'h34, 8'd4},  // R4
    {8'd0, 8'h00, 8'h00, 8'd4},
    {8'd1, 8'h00, 8'h01, 8'd4},
    {8'd0, 8'h01, 8'h00, 8'd3},
    {8'd1, 8'h01, 8'h01, 8'd3},
    {8'd0, 8'h01, 8'h7A, 8'd3},
    {8'd1, 8'h01, 8'h03, 8'd3},
    {8'd0, 8'h07, 8'h55, 8'd4},
    {8'd1, 8'h07, 8'h60, 8'd4},
    {8'd0, 8'h09, 8'h66, 8'd2},
    {8'd1, 8'h09, 8'h66, 8'd2},
    {8'd0, 8'h01, 8'h04, 8'd3},
    {8'd0, 8'h09, 8'h11, 8'd4},
    {8'd1, 8'h09, 8'h66, 8'd4},
    {8'd0, 8'h02, 8'hF5, 8'd8},
    {8'd1, 8'h02, 8'h05, 8'd8},  // R8
    {8'd0, 8'h20, 8'hFF, 8'd10},
    {8'd1, 8'h20, 8'h00, 8'd10}, // R10
    {8'd1, 8'h04, 8'h00, 8'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(base, i);
    bus_wr(base + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    bus_wr(base, i);
    @(negedge clk); addr = base + 16'd1; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic probe(input logic [15:0] a, input logic r, input logic w, output logic [2:0] cs);
    @(negedge clk); addr = a; rd = r; wr = 0;
    #1 cs = {cs_rtc, cs_kbd, cs_pm};
    if (w) begin
      rd = 0; wr = 1; wdata = 8'h00;
      #1 cs = cs | {cs_rtc, cs_kbd, cs_pm};
      addr = 16'hFFF0;
    end
    @(negedge clk); rd = 0; wr = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); strap = s; rst_n = 0; base = 16'h002E;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [2:0] cs;
    do_reset(1'b1);
    #1 check("R9 strap=1 irq_oe", {12'h0, irq_oe}, 16'h000F);
    for (int k = 0; k < 31; k++) begin
      if (VEC[k][31:24] == 8'd0) reg_wr(VEC[k][23:16], VEC[k][15:8]);
      else begin
        reg_rd(VEC[k][23:16], v);
        check($sformatf("R%0d vec%0d", VEC[k][7:0], k), {8'h0, v}, {8'h0, VEC[k][15:8]});
      end
    end
    check("R8 irq_oe", {12'h0, irq_oe}, 16'h0005);

    // R9 strap low, R1 defaults
    do_reset(1'b0);
    #1 check("R9 strap=0 irq_oe", {12'h0, irq_oe}, 16'h0000);
    reg_rd(8'h01, v); check("R1 lock after reset", {8'h0, v}, 16'h0000);
    reg_rd(8'h06, v); check("R1 rtc hi reset", {8'h0, v}, 16'h0000);
    reg_rd(8'h05, v); check("R1 rtc lo reset", {8'h0, v}, 16'h0070);
    reg_rd(8'h0A, v); check("R1 pm hi reset", {8'h0, v}, 16'h0000);
    reg_rd(8'h09, v); check("R1 pm lo reset", {8'h0, v}, 16'h0062);

    // R6 disabled channel gives no select
    probe(16'h0070, 1, 0, cs); check("R6 disabled rtc", {13'h0, cs}, 16'h0000);
    reg_wr(8'h00, 8'h07);
    probe(16'h0070, 1, 0, cs); check("R6 rtc read select", {13'h0, cs}, 16'h0004);
    probe(16'h0060, 0, 1, cs); check("R6 kbd write select", {13'h0, cs}, 16'h0002);
    probe(16'h0062, 1, 0, cs); check("R6 pm read select", {13'h0, cs}, 16'h0001);
    probe(16'h0071, 1, 0, cs); check("R6 near-miss address", {13'h0, cs}, 16'h0000);
    probe(16'h0070, 0, 0, cs); check("R6 no strobe", {13'h0, cs}, 16'h0000);
    probe(16'h1070, 1, 0, cs); check("R6 high byte differs", {13'h0, cs}, 16'h0000);

    // R7 collisions resolve by priority
    reg_wr(8'h09, 8'h70);
    probe(16'h0070, 1, 0, cs); check("R7 rtc over pm", {13'h0, cs}, 16'h0004);
    reg_wr(8'h07, 8'h70);
    reg_wr(8'h00, 8'h06);
    probe(16'h0070, 1, 0, cs); check("R7 kbd over pm", {13'h0, cs}, 16'h0002);
    reg_wr(8'h00, 8'h04);
    probe(16'h0070, 1, 0, cs); check("R7 pm alone", {13'h0, cs}, 16'h0001);

    // R2 move the window, R5 then lock it
    reg_wr(8'h03, 8'h4E);
    base = 16'h004E;
    reg_rd(8'h03, v); check("R2 moved base lo", {8'h0, v}, 16'h004E);
    reg_wr(8'h01, 8'h80);
    reg_rd(8'h01, v); check("R3 base lock bit", {8'h0, v}, 16'h0080);
    reg_wr(8'h03, 8'h2E);
    reg_wr(8'h04, 8'h11);
    reg_rd(8'h03, v); check("R5 base lo frozen", {8'h0, v}, 16'h004E);
    reg_rd(8'h04, v); check("R5 base hi frozen", {8'h0, v}, 16'h0000);
    reg_wr(8'h00, 8'h01);
    reg_rd(8'h00, v); check("R4 enables writable when unlocked", {8'h0, v}, 16'h0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule